// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers interrupt requests from eight sources of a line-interface device into one status byte and one active-low interrupt line. Seven of the sources are functional sub-blocks. Each of them supplies a pending-request level that has already been filtered by that sub-block's own enables. It also supplies a one-cycle pulse that marks a processor read of the sub-block's cause register. The eighth source is an internal one-second tick, derived from the system clock by a counter whose length is set by the `CLK_HZ` parameter.

A processor reaches the block through an address, a read strobe, a write strobe and 8-bit data. It sees two registers. The first is a read/write enable byte that holds one gate per source. A gate only passes requests that the lower level has already enabled, and a 0 blocks that source completely. The second is a read-only status byte. Status bits 7 to 1 are sticky copies of the sub-block requests, and each one is cleared through its own sub-block's register read. Status bit 0 latches the one-second event and clears when the status byte itself is read.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset the status byte and the enable byte read as 0x00 and `irq_n` is 1.
- R2: A write strobe at address `EN_ADDR` (default 4) loads `wdata` into the enable byte. A read at that address returns the enable byte. Enable bit n gates status bit n.
- R3: Status bit layout: bit 7 = `rx_req[3]` (receive framer), bit 6 = `rx_req[2]` (receive PLCP), bit 5 = `rx_req[1]` (receive cell processor), bit 4 = `rx_req[0]` (receive UTOPIA), bit 3 = `tx_utopia_req`, bit 2 = `tx_cp_req`, bit 1 = transmit framer, bit 0 = one-second. A request that is high at a clock edge sets its status bit at that edge.
- R4: A set bit among 7..1 holds while its request is low until `src_rd[n]` pulses, and it is 0 after that edge. If the request is still high at the pulse, the bit stays 1.
- R5: Status bit 1 is set by `txf_feac_req`, by `txf_lapd_req`, or by both.
- R6: Writes to the status address (`ST_ADDR`, default 5) change no status bit.
- R7: The one-second bit is set once every `CLK_HZ` clock cycles.
- R8: A status read returns the value held before the read edge, then clears bit 0. Bits 7..1 are not changed by that read.
- R9: If a tick arrives in the same cycle as a status read, bit 0 is 1 after that edge.
- R10: `irq_n` is 0 exactly when some status bit and its enable bit are both 1. With the enable byte at 0x00, `irq_n` stays 1 even with requests pending.
- R11: `rdata` is loaded at the clock edge that samples `rd_stb`. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| rd_stb | input | 1 | Read strobe, one cycle |
| wr_stb | input | 1 | Write strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_req | input | 4 | Receive sub-block pending requests (framer, PLCP, cell processor, UTOPIA; MSB first) |
| tx_utopia_req | input | 1 | Transmit UTOPIA pending request |
| tx_cp_req | input | 1 | Transmit cell processor pending request |
| txf_feac_req | input | 1 | Transmit framer FEAC request |
| txf_lapd_req | input | 1 | Transmit framer LAPD request |
| src_rd | input | 7 | Sub-block cause-register read pulses, indexed [7:1] to match status bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle the assertions check four things: a pending request sets its status bit on the next edge, a sticky bit never drops without its read pulse, a tick or a colliding status read leaves bit 0 set and a plain status read clears it, and an all-zero enable byte keeps `irq_n` high. The bench scenarios cover what a per-cycle property cannot. These are the mapping of each input to its bit position, the spacing between one-second events, a read returning the pre-clear value while a second read returns zero, and the exact cycle in which a tick meets a read.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
   localparam int NSRC    = 8;
   localparam int DATA_W  = 8;
   localparam int SEC_BIT = 0;
   localparam int TXF_BIT = 1;
   localparam int TXC_BIT = 2;
   localparam int TXU_BIT = 3;
   localparam int RXU_BIT = 4;
   localparam int RX_NUM  = 4;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
   parameter int CYCLES = 100_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CYCLES < 1) begin : g_bad
         $error("irq_tick_gen: CYCLES must be at least 1");
      end else if (CYCLES == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_aggr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:1]   req,
   input  logic [NSRC-1:1]   src_rd,
   input  logic              tick,
   input  logic              stat_rd,
   output logic [NSRC-1:0]   status
);
   logic [NSRC-1:1] sticky_q;
   logic            sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= req | (sticky_q & ~src_rd);
   end

   // a new tick wins over a clearing read so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sec_q <= 1'b0;
      else if (tick)    sec_q <= 1'b1;
      else if (stat_rd) sec_q <= 1'b0;
   end

   assign status = {sticky_q, sec_q};
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_aggr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int EN_ADDR = 4,
   parameter int ST_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NSRC-1:0]   status,
   output logic [NSRC-1:0]   en_q,
   output logic [DATA_W-1:0] rdata,
   output logic              stat_rd
);
   localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_ADDR);

   generate
      if (EN_ADDR == ST_ADDR) begin : g_bad_map
         $error("irq_reg_port: enable and status addresses collide");
      end
      if (EN_ADDR >= (1 << ADDR_W) || ST_ADDR >= (1 << ADDR_W)) begin : g_bad_w
         $error("irq_reg_port: address does not fit ADDR_W");
      end
      if (NSRC != DATA_W) begin : g_bad_d
         $error("irq_reg_port: source count must equal data width");
      end
   endgenerate

   assign stat_rd = rd_stb && (addr == ST_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      en_q <= '0;
      else if (wr_stb && addr == EN_A) en_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else if (rd_stb) begin
         if (addr == EN_A)      rdata <= en_q;
         else if (addr == ST_A) rdata <= status;
         else                   rdata <= '0;
      end
   end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
   import irq_aggr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int EN_ADDR = 4,
   parameter int ST_ADDR = 5,
   parameter int CLK_HZ  = 100_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [3:0]        rx_req,
   input  logic              tx_utopia_req,
   input  logic              tx_cp_req,
   input  logic              txf_feac_req,
   input  logic              txf_lapd_req,
   input  logic [7:1]        src_rd,
   output logic              irq_n
);
   localparam int TICK_CYCLES = CLK_HZ;

   logic [NSRC-1:1] req_vec;
   logic [NSRC-1:0] status_q;
   logic [NSRC-1:0] en_q;
   logic            tick;
   logic            stat_rd;

   assign req_vec[TXF_BIT] = txf_feac_req | txf_lapd_req;
   assign req_vec[TXC_BIT] = tx_cp_req;
   assign req_vec[TXU_BIT] = tx_utopia_req;
   assign req_vec[NSRC-1:RXU_BIT] = rx_req;

   irq_tick_gen #(.CYCLES(TICK_CYCLES)) tick_i (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   irq_status_bank stat_i (
      .clk(clk), .rst_n(rst_n), .req(req_vec), .src_rd(src_rd),
      .tick(tick), .stat_rd(stat_rd), .status(status_q)
   );

   irq_reg_port #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .ST_ADDR(ST_ADDR)) port_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wdata(wdata), .status(status_q), .en_q(en_q), .rdata(rdata),
      .stat_rd(stat_rd)
   );

   assign irq_n = ~|(status_q & en_q);
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
   parameter int ADDR_W  = 8,
   parameter int EN_ADDR = 4,
   parameter int ST_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [7:0]        wdata,
   input logic [7:1]        req_vec,
   input logic [7:1]        src_rd,
   input logic              tick,
   input logic [7:0]        status_q,
   input logic [7:0]        en_q,
   input logic              irq_n
);
   localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_ADDR);

   a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == EN_A) |=> (en_q == $past(wdata)));

   a_r3_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec != 7'd0) |=> ((status_q[7:1] & $past(req_vec)) == $past(req_vec)));

   a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q[7:1] & ~src_rd) != 7'd0) |=>
         ((status_q[7:1] & $past(status_q[7:1] & ~src_rd)) == $past(status_q[7:1] & ~src_rd)));

   a_r7_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> status_q[0]);

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr == ST_A && !tick) |=> !status_q[0]);

   a_r9_collide_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr == ST_A && tick) |=> status_q[0]);

   a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 8'h00) |-> irq_n);
endmodule

bind irq_aggr_top irq_aggr_chk #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .ST_ADDR(ST_ADDR)) chk_i (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
   .wdata(wdata), .req_vec(req_vec), .src_rd(src_rd), .tick(tick),
   .status_q(status_q), .en_q(en_q), .irq_n(irq_n)
);

// File: tb/irq_aggr_top_tb_top.sv
`timescale 1ns/1ps
module irq_aggr_top_tb_top;
   localparam int N  = 20;
   localparam logic [7:0] EN = 8'd4, ST = 8'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] addr = '0, wdata = '0, rdata;
   logic rd_stb = 1'b0, wr_stb = 1'b0;
   logic [3:0] rx_req = '0;
   logic tx_utopia_req = 1'b0, tx_cp_req = 1'b0, txf_feac_req = 1'b0, txf_lapd_req = 1'b0;
   logic [7:1] src_rd = '0;
   logic irq_n;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   irq_aggr_top #(.ADDR_W(8), .EN_ADDR(4), .ST_ADDR(5), .CLK_HZ(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wdata(wdata), .rdata(rdata), .rx_req(rx_req), .tx_utopia_req(tx_utopia_req),
      .tx_cp_req(tx_cp_req), .txf_feac_req(txf_feac_req), .txf_lapd_req(txf_lapd_req),
      .src_rd(src_rd), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      addr = a; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0; d = rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic pulse_rd(input int bitn);
      src_rd[bitn] = 1'b1;
      @(negedge clk);
      src_rd = '0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 irq_n", {7'd0, irq_n}, 8'h01);
      rd(EN, d); check("R1 enable", d, 8'h00);
      rd(ST, d); check("R1 status", d, 8'h00);
   endtask

   task automatic t_enable_rw;
      logic [7:0] d;
      wr(EN, 8'hA5); rd(EN, d); check("R2 enable A5", d, 8'hA5);
      wr(EN, 8'h00); rd(EN, d); check("R2 enable 00", d, 8'h00);
      rd(8'd9, d); check("R11 unmapped", d, 8'h00);
   endtask

   task automatic t_layout;
      logic [7:0] d;
      for (int i = 1; i < 8; i++) begin
         if (i >= 4) rx_req[i-4] = 1'b1;
         else if (i == 3) tx_utopia_req = 1'b1;
         else if (i == 2) tx_cp_req = 1'b1;
         else txf_feac_req = 1'b1;
         @(negedge clk);
         rx_req = '0; tx_utopia_req = 0; tx_cp_req = 0; txf_feac_req = 0;
         rd(ST, d); check("R3 layout", d & 8'hFE, 8'(1 << i));
         repeat (2) @(negedge clk);
         rd(ST, d); check("R4 hold", d & 8'hFE, 8'(1 << i));
         pulse_rd(i);
         rd(ST, d); check("R4 clear", d & 8'hFE, 8'h00);
      end
   endtask

   task automatic t_req_still_high;
      logic [7:0] d;
      rx_req[2] = 1'b1; @(negedge clk);
      pulse_rd(6);
      rd(ST, d); check("R4 req high at read", d & 8'hFE, 8'h40);
      rx_req[2] = 1'b0; pulse_rd(6);
      rd(ST, d); check("R4 clear after drop", d & 8'hFE, 8'h00);
   endtask

   task automatic t_txf_or;
      logic [7:0] d;
      txf_lapd_req = 1'b1; @(negedge clk); txf_lapd_req = 1'b0;
      rd(ST, d); check("R5 lapd", d & 8'hFE, 8'h02);
      pulse_rd(1);
      txf_feac_req = 1'b1; txf_lapd_req = 1'b1; @(negedge clk);
      txf_feac_req = 1'b0; txf_lapd_req = 1'b0;
      rd(ST, d); check("R5 both", d & 8'hFE, 8'h02);
      pulse_rd(1);
   endtask

   task automatic t_status_write_irq;
      logic [7:0] d;
      tx_utopia_req = 1'b1; @(negedge clk); tx_utopia_req = 1'b0;
      wr(ST, 8'h00);
      rd(ST, d); check("R6 write ignored", d & 8'hFE, 8'h08);
      check("R10 masked", {7'd0, irq_n}, 8'h01);
      wr(EN, 8'h08); check("R10 enabled", {7'd0, irq_n}, 8'h00);
      wr(EN, 8'hF6); check("R10 other gates", {7'd0, irq_n}, 8'h01);
      wr(EN, 8'h08);
      pulse_rd(3); check("R10 released", {7'd0, irq_n}, 8'h01);
      wr(EN, 8'h00);
   endtask

   task automatic t_tick;
      logic [7:0] d;
      int first = -1, second = -1;
      for (int c = 0; c < 3 * N && second < 0; c++) begin
         rd(ST, d);
         if (d[0]) begin
            if (first < 0) first = c; else second = c;
         end
      end
      check("R7 period", 8'(second - first), 8'(N));
      rd(ST, d); check("R8 cleared by read", {7'd0, d[0]}, 8'h00);
      // detection read happened at edge Er; next tick edge is Er+N-1
      repeat (N - 3) @(negedge clk);
      rd(ST, d); check("R9 collide read value", {7'd0, d[0]}, 8'h00);
      rd(ST, d); check("R9 bit kept", {7'd0, d[0]}, 8'h01);
      rx_req[3] = 1'b1; @(negedge clk); rx_req[3] = 1'b0;
      rd(ST, d); rd(ST, d); check("R8 others kept", d & 8'hFE, 8'h80);
      pulse_rd(7);
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable_rw();
      t_layout();
      t_req_still_high();
      t_txf_or();
      t_status_write_irq();
      t_tick();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule